// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block gathers a parameterised set of level-sensitive interrupt inputs (32 by default) and merges them into a single request line for a parent interrupt controller. Each source has a sticky pending flag. The flag is set while the source is high and is dropped only through an acknowledge bit that software controls. A per-source mask decides whether a pending flag is visible in the status word and whether it contributes to the merged request.

Software reaches three 32-bit registers through a plain write strobe and a combinational read port:

| Offset | Register | Access |
|--------|----------|--------|
| 0x10 | acknowledge | read/write |
| 0x14 | mask | read/write |
| 0x1c | masked status | read-only |

Bit i of every register belongs to source i. A service routine reads the status word and handles the set bits starting from the lowest. For each bit it writes that bit high in the acknowledge register and then writes it low again. The acknowledge register is not self-clearing: it keeps whatever was written last. Because of this, read-modify-write sequences on the acknowledge and mask registers behave predictably.

Top module: `irq_combiner`

## Requirements
- R1: After reset the acknowledge register, the mask register, every pending flag and `irq_o` are all 0.
- R2: A write to offset 0x10 (acknowledge) or offset 0x14 (mask) stores the full 32-bit word, and a read of that offset returns the value last written.
- R3: A pending flag is set at the clock edge where its source input is high and its acknowledge bit is 0. It stays set after the source drops.
- R4: While acknowledge bit i is 1, pending flag i is cleared at every edge and stays 0 even if source i is high, so clearing wins over a new assertion.
- R5: A read of offset 0x1c returns the pending flags ANDed with the inverted mask; a mask bit of 1 hides its source. A masked flag is still captured and appears once its mask bit returns to 0.
- R6: `irq_o` is the OR of all status bits, registered, so it changes one clock edge after the status word does.
- R7: Several flags may be pending together, and acknowledging one bit leaves the other pending bits unchanged.
- R8: A read of any offset other than 0x10, 0x14 or 0x1c returns 0. Writes to those other offsets, and writes to 0x1c, change no register and no pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level interrupt inputs, bit i = source i |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Byte offset for both reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Merged interrupt request to the parent controller |

## Verification
The bench pulses a source for a single cycle and checks that its flag survives the pulse. A design that followed the input level instead of latching it would lose the interrupt. With an acknowledge bit held at 1, the bench drives the source high and expects the flag to stay clear; a design that gave the set path priority would show a pending bit. A source that fires while masked must reappear when it is unmasked, which catches a design that gates capture instead of visibility. Acknowledging one of three simultaneous bits must leave the other two pending, and writes to the status offset or to unmapped offsets must not alter the mask, the acknowledge register or any flag. The bench also samples `irq_o` in the cycle after a flag is set to confirm the single register stage: an unregistered output would assert one cycle early.

// File: rtl/irq_cmb_pkg.sv
package irq_cmb_pkg;
  localparam int unsigned DEF_N_SRC  = 32;
  localparam int unsigned DEF_ADDR_W = 8;
  // Register offsets; software depends on these exact values.
  localparam logic [7:0] OFF_ACK  = 8'h10;
  localparam logic [7:0] OFF_MASK = 8'h14;
  localparam logic [7:0] OFF_STAT = 8'h1c;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_cmb_regs.sv
module irq_cmb_regs
  import irq_cmb_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  input  logic [N_SRC-1:0]  stat_i,
  output logic [N_SRC-1:0]  ack_q,
  output logic [N_SRC-1:0]  mask_q,
  output logic [N_SRC-1:0]  rdata,
  output reg_sel_e          sel_o
);
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(OFF_ACK))       return SEL_ACK;
    else if (a == ADDR_W'(OFF_MASK)) return SEL_MASK;
    else if (a == ADDR_W'(OFF_STAT)) return SEL_STAT;
    else                             return SEL_NONE;
  endfunction

  assign sel_o = decode(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (sel_o == SEL_ACK)  ack_q  <= wdata;
      if (sel_o == SEL_MASK) mask_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel_o)
      SEL_ACK:  rdata = ack_q;
      SEL_MASK: rdata = mask_q;
      SEL_STAT: rdata = stat_i;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cmb_pend.sv
module irq_cmb_pend #(
  parameter int unsigned N_SRC = irq_cmb_pkg::DEF_N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] pend_q,
  output logic [N_SRC-1:0] set_ev,
  output logic [N_SRC-1:0] clr_ev
);
  // Next flag value: the acknowledge bit dominates, otherwise sticky set.
  function automatic logic next_flag(input logic cur, input logic src, input logic ack);
    return ack ? 1'b0 : (cur | src);
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    assign set_ev[i] = src_i[i] & ~ack_i[i] & ~pend_q[i];
    assign clr_ev[i] = ack_i[i] & pend_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= next_flag(pend_q[i], src_i[i], ack_i[i]);
    end
  end
endmodule

// File: rtl/irq_cmb_out.sv
module irq_cmb_out #(
  parameter int unsigned N_SRC = irq_cmb_pkg::DEF_N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic [N_SRC-1:0] stat_o,
  output logic             any_w,
  output logic             irq_q
);
  function automatic logic [N_SRC-1:0] visible(input logic [N_SRC-1:0] p,
                                               input logic [N_SRC-1:0] m);
    return p & ~m;
  endfunction

  assign stat_o = visible(pend_i, mask_i);
  assign any_w  = |stat_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_w;
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_cmb_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC-1:0]  wdata,
  output logic [N_SRC-1:0]  rdata,
  output logic              irq_o
);
  logic [N_SRC-1:0] ack_q, mask_q, pend_q, stat_w, set_ev, clr_ev;
  logic             any_w;
  reg_sel_e         sel_w;

  irq_cmb_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .stat_i(stat_w), .ack_q(ack_q), .mask_q(mask_q), .rdata(rdata), .sel_o(sel_w)
  );

  irq_cmb_pend #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ack_i(ack_q),
    .pend_q(pend_q), .set_ev(set_ev), .clr_ev(clr_ev)
  );

  irq_cmb_out #(.N_SRC(N_SRC)) u_out (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_q), .mask_i(mask_q),
    .stat_o(stat_w), .any_w(any_w), .irq_q(irq_o)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk
  import irq_cmb_pkg::*;
#(
  parameter int unsigned N_SRC = DEF_N_SRC
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_i,
  input logic             wr_en,
  input reg_sel_e         sel_w,
  input logic [N_SRC-1:0] ack_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] stat_w,
  input logic             irq_o
);
  // R3
  pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & ~ack_q) != '0) |=> ((pend_q & $past(src_i & ~ack_q)) == $past(src_i & ~ack_q)));

  // R3
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q != '0) && (ack_q == '0)) |=> (($past(pend_q) & ~pend_q) == '0));

  // R4
  ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q != '0) |=> ((pend_q & $past(ack_q)) == '0));

  // R5
  mask_hides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_w & mask_q) == '0));

  // R6
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w != '0) |=> irq_o);

  // R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w == '0) |=> !irq_o);

  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel_w == SEL_NONE || sel_w == SEL_STAT)) |=> ($stable(ack_q) && $stable(mask_q)));
endmodule

bind irq_combiner irq_combiner_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .sel_w(sel_w),
  .ack_q(ack_q), .mask_q(mask_q), .pend_q(pend_q), .stat_w(stat_w), .irq_o(irq_o)
);

// File: tb/test_irq_combiner.sv
module test_irq_combiner;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_combiner i_irq_combiner (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ack(input int n);
    bwr(8'h10, 32'h1 << n);
    bwr(8'h10, 32'h0);
  endtask

  task automatic pulse(input logic [31:0] bits);
    @(negedge clk); src_i = bits;
    @(negedge clk); src_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    brd(8'h10, d); chk("R1 ack reset", d, 0);
    brd(8'h14, d); chk("R1 mask reset", d, 0);
    brd(8'h1c, d); chk("R1 status reset", d, 0);
    chk("R1 irq reset", {31'b0, irq_o}, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bwr(8'h14, 32'hA5A5_0F0F); brd(8'h14, d); chk("R2 mask readback", d, 32'hA5A5_0F0F);
    bwr(8'h10, 32'h8000_0001); brd(8'h10, d); chk("R2 ack readback", d, 32'h8000_0001);
    bwr(8'h10, 32'h0); bwr(8'h14, 32'h0);
    brd(8'h14, d); chk("R2 mask restore", d, 0);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    @(negedge clk); src_i = 32'h8;
    @(negedge clk); src_i = '0;
    brd(8'h1c, d); chk("R3 flag set", d, 32'h8);
    chk("R6 irq one cycle later", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R6 irq asserted", {31'b0, irq_o}, 1);
    repeat (3) @(negedge clk);
    brd(8'h1c, d); chk("R3 flag sticky", d, 32'h8);
    ack(3);
    @(negedge clk);
    brd(8'h1c, d); chk("R3 flag acked", d, 0);
    chk("R6 irq dropped", {31'b0, irq_o}, 0);
  endtask

  task automatic t_ack_wins();
    logic [31:0] d;
    bwr(8'h10, 32'h20);
    @(negedge clk); src_i = 32'h20;
    repeat (3) @(negedge clk);
    brd(8'h1c, d); chk("R4 held clear under source", d, 0);
    chk("R4 irq stays low", {31'b0, irq_o}, 0);
    src_i = '0;
    bwr(8'h10, 32'h0);
    @(negedge clk);
    brd(8'h1c, d); chk("R4 nothing left after release", d, 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bwr(8'h14, 32'h80);
    pulse(32'h80);
    @(negedge clk);
    brd(8'h1c, d); chk("R5 masked hidden", d, 0);
    chk("R5 masked no irq", {31'b0, irq_o}, 0);
    bwr(8'h14, 32'h0);
    brd(8'h1c, d); chk("R5 unmask reveals", d, 32'h80);
    @(negedge clk);
    chk("R5 irq after unmask", {31'b0, irq_o}, 1);
    ack(7);
    @(negedge clk);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    pulse(32'h4000_0012);
    brd(8'h1c, d); chk("R7 three pending", d, 32'h4000_0012);
    ack(1);
    brd(8'h1c, d); chk("R7 ack lowest only", d, 32'h4000_0010);
    chk("R7 irq still high", {31'b0, irq_o}, 1);
    ack(4);
    brd(8'h1c, d); chk("R7 ack second", d, 32'h4000_0000);
    ack(30);
    @(negedge clk);
    brd(8'h1c, d); chk("R7 all acked", d, 0);
    chk("R7 irq low", {31'b0, irq_o}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse(32'h4);
    bwr(8'h18, 32'hFFFF_FFFF);
    brd(8'h18, d); chk("R8 unmapped reads zero", d, 0);
    brd(8'h11, d); chk("R8 misaligned reads zero", d, 0);
    bwr(8'h1c, 32'hFFFF_FFFF);
    brd(8'h1c, d); chk("R8 status write ignored", d, 32'h4);
    brd(8'h14, d); chk("R8 mask untouched", d, 0);
    brd(8'h10, d); chk("R8 ack untouched", d, 0);
    ack(2);
    brd(8'h1c, d); chk("R8 cleanup", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_capture();
    t_ack_wins();
    t_mask();
    t_multi();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule